// File: doc/BRIEF.md
# Nibble Mailbox Between Host and Audio Processors

This block links a host processor and an audio processor that sit on separate 8-bit buses. Each side sees two registers: a pointer register and a data register. Traffic moves four bits at a time through two mailboxes of four nibble slots each. One mailbox carries host-to-audio traffic and the other carries audio-to-host traffic. Each data access in a slot mode moves that side's pointer on to the next slot, so software can stream a pair of nibbles after one pointer write.

Slots 0/1 and 2/3 form pairs. Writing the upper nibble of a pair (slot 1 or slot 3) raises a "pair full" flag toward the other side, and reading that slot on the far side drops the flag. A host write that completes a pair also sets a pending interrupt toward the audio processor. The audio side can mask that interrupt. Pointer codes above the slot range select the shared status nibble, the audio-processor reset line, and interrupt mask control.

Top module: `nibble_mailbox`

## Requirements
- R1: Every value written on either side, whether to the pointer register or to the data register, is cut to its low 4 bits before use.
- R2: `host_mode_err` is 1 while the host pointer holds a value above 4, and `aud_mode_err` is 1 while the audio pointer holds a value above 6. Otherwise each is 0.
- R3: A host data write with pointer 0..3 stores the nibble into host-to-audio slot [pointer] and adds 1 to the host pointer.
- R4: An audio data write with pointer 0..3 stores the nibble into audio-to-host slot [pointer] and adds 1 to the audio pointer.
- R5: A data read with pointer 0..3 returns the opposite mailbox's slot [pointer] in bits 3:0 of the read data, with bits 7:4 zero, and adds 1 to that side's pointer.
- R6: A read with pointer 4 on either side returns the status nibble and leaves the pointer at 4. The status bits are: bit0 = slots 0/1 full toward audio, bit1 = slots 2/3 full toward audio, bit2 = slots 0/1 full toward host, bit3 = slots 2/3 full toward host.
- R7: A read with an undefined pointer returns 0 and leaves the pointer unchanged. A data write with an undefined pointer, or an audio data write with pointer 4, changes nothing.
- R8: Writing slot 1 or slot 3 sets the matching full flag toward the other side. Reading slot 1 or slot 3 clears the matching flag toward the reader.
- R9: A host write to slot 1 or slot 3 sets the pending interrupt, and an audio read of slot 1 or slot 3 clears it. An audio data write with pointer 5 masks the interrupt and one with pointer 6 unmasks it. `aud_nmi` = pending AND unmasked.
- R10: A host data write with pointer 4 drives `aud_reset` to 1 if the masked value is nonzero and to 0 if it is zero.
- R11: If one cycle both sets and clears the same full flag or the pending interrupt, the set wins.
- R12: Within one side, a pointer write takes priority over a data write, and a data write takes priority over a read. Only the highest-priority access present in a cycle acts.
- R13: After reset, both pointers, all slots and flags, and the pending interrupt are 0, the interrupt is masked, and `aud_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ptr_we | input | 1 | Host write strobe for the pointer register |
| host_data_we | input | 1 | Host write strobe for the data register |
| host_data_re | input | 1 | Host read strobe for the data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current pointer |
| host_mode_err | output | 1 | Host pointer holds an undefined code |
| aud_ptr_we | input | 1 | Audio write strobe for the pointer register |
| aud_data_we | input | 1 | Audio write strobe for the data register |
| aud_data_re | input | 1 | Audio read strobe for the data register |
| aud_wdata | input | 8 | Audio write data |
| aud_rdata | output | 8 | Audio read data for the current pointer |
| aud_mode_err | output | 1 | Audio pointer holds an undefined code |
| aud_nmi | output | 1 | Interrupt request to the audio processor |
| aud_reset | output | 1 | Reset line to the audio processor |

## Verification
Two kinds of collision can fall in the same cycle. In the first, one side writes the upper nibble of a pair while the other side reads that same slot, so one full flag is set and cleared at once. In the second, a host pair write and an audio pair read hit the pending interrupt together. The bench sets both pointers to slot 1 and then drives a host write with an audio read in one cycle, and later an audio write with a host read. Each case is judged through the status nibble and `aud_nmi`: both must show the set winning, and the read must return the slot value from before the write.

// File: rtl/mbx_pkg.sv
// Package: shared codes for the nibble mailbox.
// Assumes four slots per mailbox, grouped into two pairs.
package mbx_pkg;
    localparam int SLOT_CNT   = 4;
    localparam int PAIR_CNT   = SLOT_CNT / 2;
    localparam int CODE_W     = 4;
    localparam int CODE_STAT  = 4;
    localparam int CODE_MASK  = 5;
    localparam int CODE_UNMSK = 6;
    localparam int HOST_MAX   = 4;
    localparam int AUD_MAX    = 6;
endpackage

// File: rtl/mbx_side_ctl.sv
// Module: per-side pointer register and access decode.
// Resolves priority between the three strobes (pointer write, data write,
// read), keeps the auto-incrementing pointer, and reports which slot,
// pair or control action the accepted access hits.
// Assumes that only accesses with a pointer inside the slot range advance.
module mbx_side_ctl #(
    parameter int CODE_W   = 4,
    parameter int SLOTS    = 4,
    parameter int MAX_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] ptr,
    output logic              slot_wr,
    output logic              slot_rd,
    output logic [SLOTS/2-1:0] pair_wr,
    output logic [SLOTS/2-1:0] pair_rd,
    output logic              ctl_wr,
    output logic              err
);
    localparam int PAIRS = SLOTS / 2;
    localparam logic [CODE_W-1:0] SLOT_LIM = CODE_W'(SLOTS);
    localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(MAX_CODE);

    logic eff_we, eff_re, in_slots;

    // Priority: pointer write, then data write, then read.
    always_comb begin
        eff_we   = data_we & ~ptr_we;
        eff_re   = data_re & ~ptr_we & ~data_we;
        in_slots = ptr < SLOT_LIM;
        slot_wr  = eff_we & in_slots;
        slot_rd  = eff_re & in_slots;
        ctl_wr   = eff_we & ~in_slots & (ptr <= CODE_LIM);
        err      = ptr > CODE_LIM;
    end

    // Upper slot of each pair flags a completed pair.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        localparam logic [CODE_W-1:0] HI = CODE_W'(2 * k + 1);
        assign pair_wr[k] = slot_wr & (ptr == HI);
        assign pair_rd[k] = slot_rd & (ptr == HI);
    end

    // Pointer register: load on pointer write, advance on slot access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_we)
            ptr <= din;
        else if (slot_wr || slot_rd)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/mbx_slots.sv
// Module: one mailbox of nibble slots, one write port, one read port.
// Assumes that the caller qualifies the write enable with a slot-range check.
module mbx_slots #(
    parameter int NIB_W = 4,
    parameter int SLOTS = 4,
    parameter int SEL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NIB_W-1:0] din,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [NIB_W-1:0] dout
);
    logic [NIB_W-1:0] mem [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Slot storage: clear on reset, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && wr_sel == SEL_W'(i))
                mem[i] <= din;
        end
    end

    // Read mux over the slots.
    always_comb dout = mem[rd_sel];
endmodule

// File: rtl/nibble_mailbox.sv
// Module: top of the two-way nibble mailbox.
// Holds the status flags, the pending interrupt and its mask, and the
// audio reset line. Builds each side's read data from its pointer.
// Assumes single-cycle register accesses on both buses.
module nibble_mailbox
    import mbx_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_ptr_we,
    input  logic             host_data_we,
    input  logic             host_data_re,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic             host_mode_err,
    input  logic             aud_ptr_we,
    input  logic             aud_data_we,
    input  logic             aud_data_re,
    input  logic [BUS_W-1:0] aud_wdata,
    output logic [BUS_W-1:0] aud_rdata,
    output logic             aud_mode_err,
    output logic             aud_nmi,
    output logic             aud_reset
);
    localparam int SEL_W = $clog2(SLOT_CNT);
    localparam int STAT_W = 2 * PAIR_CNT;
    localparam logic [CODE_W-1:0] STAT_CODE = CODE_W'(CODE_STAT);
    localparam logic [CODE_W-1:0] SLOT_LIM  = CODE_W'(SLOT_CNT);

    logic [CODE_W-1:0]   h_nib, a_nib, h_ptr, a_ptr;
    logic                h_slot_wr, h_slot_rd, h_ctl_wr, a_slot_wr, a_slot_rd, a_ctl_wr;
    logic [PAIR_CNT-1:0] h_pair_wr, h_pair_rd, a_pair_wr, a_pair_rd;
    logic [CODE_W-1:0]   h2a_dout, a2h_dout;
    logic [STAT_W-1:0]   status_q;
    logic                nmi_req, nmi_en;

    assign h_nib = host_wdata[CODE_W-1:0];
    assign a_nib = aud_wdata[CODE_W-1:0];

    mbx_side_ctl #(.CODE_W(CODE_W), .SLOTS(SLOT_CNT), .MAX_CODE(HOST_MAX)) u_host (
        .clk(clk), .rst_n(rst_n), .ptr_we(host_ptr_we), .data_we(host_data_we),
        .data_re(host_data_re), .din(h_nib), .ptr(h_ptr), .slot_wr(h_slot_wr),
        .slot_rd(h_slot_rd), .pair_wr(h_pair_wr), .pair_rd(h_pair_rd),
        .ctl_wr(h_ctl_wr), .err(host_mode_err)
    );

    mbx_side_ctl #(.CODE_W(CODE_W), .SLOTS(SLOT_CNT), .MAX_CODE(AUD_MAX)) u_aud (
        .clk(clk), .rst_n(rst_n), .ptr_we(aud_ptr_we), .data_we(aud_data_we),
        .data_re(aud_data_re), .din(a_nib), .ptr(a_ptr), .slot_wr(a_slot_wr),
        .slot_rd(a_slot_rd), .pair_wr(a_pair_wr), .pair_rd(a_pair_rd),
        .ctl_wr(a_ctl_wr), .err(aud_mode_err)
    );

    // Host-to-audio mailbox: written by host, read by audio.
    mbx_slots #(.NIB_W(CODE_W), .SLOTS(SLOT_CNT)) u_h2a (
        .clk(clk), .rst_n(rst_n), .we(h_slot_wr), .wr_sel(h_ptr[SEL_W-1:0]),
        .din(h_nib), .rd_sel(a_ptr[SEL_W-1:0]), .dout(h2a_dout)
    );

    // Audio-to-host mailbox: written by audio, read by host.
    mbx_slots #(.NIB_W(CODE_W), .SLOTS(SLOT_CNT)) u_a2h (
        .clk(clk), .rst_n(rst_n), .we(a_slot_wr), .wr_sel(a_ptr[SEL_W-1:0]),
        .din(a_nib), .rd_sel(h_ptr[SEL_W-1:0]), .dout(a2h_dout)
    );

    for (genvar k = 0; k < PAIR_CNT; k++) begin : g_flag
        // Full toward audio: set by host pair write, cleared by audio pair read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[k] <= 1'b0;
            else if (h_pair_wr[k])
                status_q[k] <= 1'b1;
            else if (a_pair_rd[k])
                status_q[k] <= 1'b0;
        end
        // Full toward host: set by audio pair write, cleared by host pair read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[PAIR_CNT+k] <= 1'b0;
            else if (a_pair_wr[k])
                status_q[PAIR_CNT+k] <= 1'b1;
            else if (h_pair_rd[k])
                status_q[PAIR_CNT+k] <= 1'b0;
        end
    end

    // Pending interrupt: host pair write sets it, audio pair read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_req <= 1'b0;
        else if (|h_pair_wr)
            nmi_req <= 1'b1;
        else if (|a_pair_rd)
            nmi_req <= 1'b0;
    end

    // Interrupt mask: audio control writes with codes 5 and 6.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_en <= 1'b0;
        else if (a_ctl_wr && a_ptr == CODE_W'(CODE_MASK))
            nmi_en <= 1'b0;
        else if (a_ctl_wr && a_ptr == CODE_W'(CODE_UNMSK))
            nmi_en <= 1'b1;
    end

    // Audio reset line: level set by host control write with code 4.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aud_reset <= 1'b0;
        else if (h_ctl_wr && h_ptr == STAT_CODE)
            aud_reset <= |h_nib;
    end

    assign aud_nmi = nmi_req & nmi_en;

    // Host read data: audio-to-host slot, status, or zero.
    always_comb begin
        host_rdata = '0;
        if (h_ptr < SLOT_LIM)
            host_rdata[CODE_W-1:0] = a2h_dout;
        else if (h_ptr == STAT_CODE)
            host_rdata[STAT_W-1:0] = status_q;
    end

    // Audio read data: host-to-audio slot, status, or zero.
    always_comb begin
        aud_rdata = '0;
        if (a_ptr < SLOT_LIM)
            aud_rdata[CODE_W-1:0] = h2a_dout;
        else if (a_ptr == STAT_CODE)
            aud_rdata[STAT_W-1:0] = status_q;
    end
endmodule

// File: rtl/mbx_checker.sv
// Module: property checker for the nibble mailbox, attached by bind.
// Assumes that it sees the top ports plus the pointers, status and interrupt state.
module mbx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ptr_we,
    input logic       host_data_we,
    input logic       host_data_re,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       host_mode_err,
    input logic       aud_ptr_we,
    input logic       aud_data_we,
    input logic       aud_data_re,
    input logic       aud_mode_err,
    input logic       aud_nmi,
    input logic [3:0] h_ptr,
    input logic [3:0] a_ptr,
    input logic [3:0] status_q,
    input logic       nmi_en
);
    // R1
    ptr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ptr_we |=> h_ptr == $past(host_wdata[3:0]));

    // R2
    host_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ptr_we && host_wdata[3:0] > 4'd4) |=> host_mode_err);

    // R2
    aud_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_ptr_we && $past(1'b1) && 1'b1) |=> (aud_mode_err == (a_ptr > 4'd6)));

    // R3
    host_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ptr_we && host_data_we && h_ptr < 4'd4) |=> h_ptr == $past(h_ptr) + 4'd1);

    // R7
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && h_ptr > 4'd4) |-> host_rdata == 8'd0);

    // R7
    undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ptr_we && h_ptr > 4'd4) |=> $stable(h_ptr));

    // R9
    nmi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_nmi |-> nmi_en);

    // R8
    pair_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ptr_we && host_data_we && h_ptr == 4'd1) |=> status_q[0]);

    // R12
    aud_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aud_ptr_we && aud_data_we && aud_data_re && a_ptr < 4'd4) |=> a_ptr == $past(a_ptr) + 4'd1);
endmodule

bind nibble_mailbox mbx_checker chk_i (
    .clk(clk), .rst_n(rst_n),
    .host_ptr_we(host_ptr_we), .host_data_we(host_data_we), .host_data_re(host_data_re),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_mode_err(host_mode_err),
    .aud_ptr_we(aud_ptr_we), .aud_data_we(aud_data_we), .aud_data_re(aud_data_re),
    .aud_mode_err(aud_mode_err), .aud_nmi(aud_nmi),
    .h_ptr(h_ptr), .a_ptr(a_ptr), .status_q(status_q), .nmi_en(nmi_en)
);

// File: tb/nibble_mailbox_tb_top.sv
// Bench: directed scenarios, one task each, checked at the ports.
module nibble_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_ptr_we = 0, host_data_we = 0, host_data_re = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_mode_err;
    logic       aud_ptr_we = 0, aud_data_we = 0, aud_data_re = 0;
    logic [7:0] aud_wdata = 0;
    logic [7:0] aud_rdata;
    logic       aud_mode_err, aud_nmi, aud_reset;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;
    logic [7:0] r;

    always #10 clk = ~clk;

    nibble_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_ptr_we(host_ptr_we), .host_data_we(host_data_we), .host_data_re(host_data_re),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_mode_err(host_mode_err),
        .aud_ptr_we(aud_ptr_we), .aud_data_we(aud_data_we), .aud_data_re(aud_data_re),
        .aud_wdata(aud_wdata), .aud_rdata(aud_rdata), .aud_mode_err(aud_mode_err),
        .aud_nmi(aud_nmi), .aud_reset(aud_reset)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_bus();
        host_ptr_we = 0; host_data_we = 0; host_data_re = 0;
        aud_ptr_we = 0; aud_data_we = 0; aud_data_re = 0;
    endtask

    task automatic h_ptr(input logic [7:0] v);
        @(negedge clk); host_ptr_we = 1; host_wdata = v;
        @(negedge clk); clear_bus();
    endtask
    task automatic h_wr(input logic [7:0] v);
        @(negedge clk); host_data_we = 1; host_wdata = v;
        @(negedge clk); clear_bus();
    endtask
    task automatic h_rd(output logic [7:0] v);
        @(negedge clk); host_data_re = 1; #5 v = host_rdata;
        @(negedge clk); clear_bus();
    endtask
    task automatic a_ptr(input logic [7:0] v);
        @(negedge clk); aud_ptr_we = 1; aud_wdata = v;
        @(negedge clk); clear_bus();
    endtask
    task automatic a_wr(input logic [7:0] v);
        @(negedge clk); aud_data_we = 1; aud_wdata = v;
        @(negedge clk); clear_bus();
    endtask
    task automatic a_rd(output logic [7:0] v);
        @(negedge clk); aud_data_re = 1; #5 v = aud_rdata;
        @(negedge clk); clear_bus();
    endtask

    task automatic t_reset();
        check("R13 aud_nmi", aud_nmi, 0);
        check("R13 aud_reset", aud_reset, 0);
        check("R13 host_mode_err", host_mode_err, 0);
        h_ptr(8'h04); h_rd(r); check("R13 status", r, 0);
        h_ptr(8'h00); h_rd(r); check("R13 slot0", r, 0);
    endtask

    task automatic t_host_to_aud();
        h_ptr(8'h30);                       // R1: masks to pointer 0
        h_wr(8'h3A); h_wr(8'h1B); h_wr(8'h0C); h_wr(8'hFD);
        check("R9 masked nmi", aud_nmi, 0);
        a_ptr(8'h04); a_rd(r); check("R6 R8 status", r, 8'h03);
        a_ptr(8'h06); a_wr(8'h00); check("R9 unmask", aud_nmi, 1);
        a_ptr(8'h00);
        a_rd(r); check("R3 R5 slot0", r, 8'h0A);
        a_rd(r); check("R3 R5 slot1", r, 8'h0B);
        check("R9 clear on read", aud_nmi, 0);
        a_rd(r); check("R1 slot2", r, 8'h0C);
        a_rd(r); check("R1 slot3", r, 8'h0D);
        a_rd(r); check("R6 R8 status cleared", r, 8'h00);
        a_rd(r); check("R6 stays", r, 8'h00);
    endtask

    task automatic t_aud_to_host();
        a_ptr(8'h00);
        a_wr(8'h05); a_wr(8'h06); a_wr(8'h07); a_wr(8'h08);
        h_ptr(8'h04); h_rd(r); check("R4 R8 status", r, 8'h0C);
        h_rd(r); check("R6 ptr held", r, 8'h0C);
        h_ptr(8'h00);
        h_rd(r); check("R4 slot0", r, 5);
        h_rd(r); check("R4 slot1", r, 6);
        h_rd(r); check("R4 slot2", r, 7);
        h_rd(r); check("R4 slot3", r, 8);
        h_rd(r); check("R8 flags cleared", r, 0);
    endtask

    task automatic t_priority();
        @(negedge clk); host_ptr_we = 1; host_data_re = 1; host_wdata = 8'h02;
        @(negedge clk); clear_bus();
        h_rd(r); check("R12 ptr beats read", r, 7);
        h_ptr(8'h00);
        @(negedge clk); host_data_we = 1; host_data_re = 1; host_wdata = 8'h09;
        @(negedge clk); clear_bus();
        h_rd(r); check("R12 single advance", r, 6);
        a_ptr(8'h00); a_rd(r); check("R12 write beats read", r, 9);
    endtask

    task automatic t_nmi();
        h_ptr(8'h01); h_wr(8'h04); check("R9 pair raises nmi", aud_nmi, 1);
        a_ptr(8'h05); a_wr(8'h00); check("R9 mask", aud_nmi, 0);
        a_ptr(8'h06); a_wr(8'h00); check("R9 unmask", aud_nmi, 1);
        a_ptr(8'h01); a_rd(r); check("R5 slot1", r, 4);
        check("R9 cleared", aud_nmi, 0);
        h_ptr(8'h04); h_rd(r); check("R8 status", r, 0);
    endtask

    task automatic t_collision();
        h_ptr(8'h01); a_ptr(8'h01);
        @(negedge clk); host_data_we = 1; host_wdata = 8'h07; aud_data_re = 1;
        #5 r = aud_rdata;
        @(negedge clk); clear_bus();
        check("R11 read sees old", r, 4);
        check("R11 nmi set wins", aud_nmi, 1);
        h_ptr(8'h04); h_rd(r); check("R11 flag set wins", r, 8'h01);
        a_ptr(8'h01); h_ptr(8'h01);
        @(negedge clk); aud_data_we = 1; aud_wdata = 8'h0E; host_data_re = 1;
        #5 r = host_rdata;
        @(negedge clk); clear_bus();
        check("R11 host read old", r, 6);
        h_ptr(8'h04); h_rd(r); check("R11 host flag", r, 8'h05);
        a_ptr(8'h01); a_rd(r); h_ptr(8'h01); h_rd(r); check("R4 slot1 new", r, 8'h0E);
        h_ptr(8'h04); h_rd(r); check("R8 all clear", r, 0);
    endtask

    task automatic t_reset_line();
        h_ptr(8'h04); h_wr(8'h05); check("R10 assert", aud_reset, 1);
        h_wr(8'h10); check("R1 R10 release", aud_reset, 0);
    endtask

    task automatic t_undefined();
        h_ptr(8'h25); check("R1 R2 host err", host_mode_err, 1);
        h_ptr(8'h04); check("R2 host ok", host_mode_err, 0);
        h_ptr(8'h0F);
        h_rd(r); check("R7 undef read", r, 0);
        h_rd(r); check("R7 ptr held", r, 0);
        h_wr(8'h0F); h_rd(r); check("R7 undef write", r, 0);
        check("R7 reset untouched", aud_reset, 0);
        a_ptr(8'h07); check("R2 aud err", aud_mode_err, 1);
        a_ptr(8'h16); check("R1 R2 aud ok", aud_mode_err, 0);
        a_ptr(8'h04); a_wr(8'h0F); a_rd(r); check("R7 aud code4 write", r, 0);
        h_ptr(8'h01); h_wr(8'h02); check("R7 mask kept", aud_nmi, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host_to_aud();
        t_aud_to_host();
        t_priority();
        t_nmi();
        t_collision();
        t_reset_line();
        t_undefined();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R13 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule